// File: doc/BRIEF.md
# Majority Background Vector Selector

This block takes a test sequence one vector per cycle and picks a single background vector for it. For every bit position it counts how many accepted vectors hold a one. Because the sequence length is known, it also knows how many hold a zero. When the vector flagged as last is accepted, each background bit takes the majority value of its position. A position where ones and zeros are equal takes a bit from a seedable pseudo-random register, so the choice is repeatable.

Against the chosen vector the block also reports the number of mismatching entries. This count is the sum over positions of the minority count, so it needs no second pass over the data. It then prices two ways of storing the sequence. Raw storage costs the vector width times the length. Mismatch-list storage costs the mismatch count times the bit width of one entry index. A mode flag reports which of the two is cheaper. All results are registered and appear together with a one-cycle valid pulse.

Top module: `bgv_selector`

## Requirements
- R1: After synchronous reset, res_valid, bg_vec, diff_cnt, raw_cost, bg_cost and use_bg are all zero.
- R2: Only cycles with in_valid high count. Bit position i is in_vec[i]. bg_vec[i] is 1 when more counted vectors hold a one than a zero at position i, and 0 when more hold a zero.
- R3: On a tie at position i, bg_vec[i] equals bit (i mod LFSR_W) of a shift register. That register shifts toward the MSB, with the XOR of the bits selected by TAP_MASK entering bit 0. It steps once per produced result. seed_load copies seed_val into it, and a zero seed is replaced by 1.
- R4: diff_cnt equals the sum over all positions of min(zero count, one count).
- R5: raw_cost equals VEC_W times the sequence length. bg_cost equals diff_cnt times ceil(log2(raw_cost)), taking ceil(log2(1)) as 0.
- R6: use_bg is 1 only when bg_cost is strictly less than raw_cost. Equal costs choose raw storage.
- R7: res_valid is high for exactly the cycle after the edge that accepts in_valid with in_last. All result outputs keep their values until the next result.
- R8: The vector marked last is included in the result. The next sequence starts from zero counts.
- R9: clr zeroes the length and all position counts. A vector presented in the same cycle as clr is dropped, even if marked last, and produces no result.
- R10: Once MAX_LEN vectors have been counted, further vectors of the sequence are not counted. A last flag on such a vector still produces the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero all counts, dropping the current vector |
| seed_load | input | 1 | Load seed_val into the tie-break register |
| seed_val | input | LFSR_W | Seed value for the tie-break register |
| in_valid | input | 1 | in_vec holds a vector of the sequence |
| in_vec | input | VEC_W | Input vector; bit i is position i |
| in_last | input | 1 | This vector ends the sequence |
| bg_vec | output | VEC_W | Chosen background vector |
| diff_cnt | output | RAW_W | Entries differing from bg_vec |
| raw_cost | output | RAW_W | Raw storage cost in bits |
| bg_cost | output | COST_W | Mismatch-list storage cost in bits |
| use_bg | output | 1 | Mismatch-list storage is cheaper |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume in_last is only meaningful together with in_valid, and that reset is applied before the first sequence. They also assume the inputs carry known values on every edge after reset. The bench drives every input from a defined value at each falling edge and raises in_last only on valid cycles. Some corner cases need tie patterns, the length cap or a same-cycle clear, so the bench produces them through the ordinary vector stream rather than by forcing state. It uses a small MAX_LEN so that the cap is reached quickly.

// File: rtl/bgv_pkg.sv
package bgv_pkg;

  // Smallest r with 2**r >= x; 0 for x <= 1.
  function automatic int ceil_log2(input logic [31:0] x);
    int r;
    r = 0;
    if (x > 32'd1) begin
      for (int b = 0; b < 32; b++) begin
        if (((x - 32'd1) >> b) != 32'd0) r = b + 1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/bgv_bit_tally.sv
module bgv_bit_tally #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] ones_nxt_o
);
  logic [CNT_W-1:0] ones_q;

  assign ones_nxt_o = ones_q + CNT_W'(inc_i);

  always_ff @(posedge clk) begin
    if (rst || zero_i) ones_q <= '0;
    else               ones_q <= ones_nxt_o;
  end
endmodule

// File: rtl/bgv_tie_lfsr.sv
module bgv_tie_lfsr #(
  parameter int              LFSR_W   = 16,
  parameter int              OUT_W    = 8,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] RST_SEED = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [OUT_W-1:0]  tie_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = ^(state_q & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst)                  state_q <= RST_SEED;
    else if (load_i)          state_q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else if (step_i)          state_q <= {state_q[LFSR_W-2:0], fb};
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_tie
    assign tie_o[i] = state_q[i % LFSR_W];
  end
endmodule

// File: rtl/bgv_vote_cost.sv
module bgv_vote_cost
  import bgv_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int CNT_W  = 11,
  parameter int RAW_W  = 14,
  parameter int COST_W = 18
) (
  input  logic [VEC_W*CNT_W-1:0] ones_i,
  input  logic [CNT_W-1:0]       len_i,
  input  logic [VEC_W-1:0]       tie_i,
  output logic [VEC_W-1:0]       bg_o,
  output logic [RAW_W-1:0]       diff_o,
  output logic [RAW_W-1:0]       raw_o,
  output logic [COST_W-1:0]      cost_o,
  output logic                   use_bg_o
);
  int idx_w;

  always_comb begin
    logic [CNT_W-1:0] n1;
    logic [CNT_W-1:0] n0;
    diff_o = '0;
    for (int i = 0; i < VEC_W; i++) begin
      n1 = ones_i[i*CNT_W +: CNT_W];
      n0 = len_i - n1;
      if (n1 > n0)      bg_o[i] = 1'b1;
      else if (n0 > n1) bg_o[i] = 1'b0;
      else              bg_o[i] = tie_i[i];
      diff_o = diff_o + RAW_W'((n1 < n0) ? n1 : n0);
    end
    raw_o    = RAW_W'(len_i) * RAW_W'(VEC_W);
    idx_w    = ceil_log2(32'(raw_o));
    cost_o   = COST_W'(diff_o) * COST_W'(idx_w);
    use_bg_o = (cost_o < COST_W'(raw_o));
  end
endmodule

// File: rtl/bgv_selector.sv
module bgv_selector #(
  parameter int                VEC_W    = 8,
  parameter int                MAX_LEN  = 1024,
  parameter int                LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] RST_SEED = 16'h0001,
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int RAW_W  = $clog2(VEC_W * MAX_LEN + 1),
  localparam int COST_W = RAW_W + $clog2(RAW_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_val,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_vec,
  input  logic              in_last,
  output logic [VEC_W-1:0]  bg_vec,
  output logic [RAW_W-1:0]  diff_cnt,
  output logic [RAW_W-1:0]  raw_cost,
  output logic [COST_W-1:0] bg_cost,
  output logic              use_bg,
  output logic              res_valid
);
  logic [CNT_W-1:0]       len_q, len_nxt;
  logic                   accept, finish;
  logic [VEC_W*CNT_W-1:0] ones_nxt;
  logic [VEC_W-1:0]       tie_bits, bg_d;
  logic [RAW_W-1:0]       diff_d, raw_d;
  logic [COST_W-1:0]      cost_d;
  logic                   use_bg_d;

  assign accept  = in_valid && !clr && (len_q < CNT_W'(MAX_LEN));
  assign finish  = in_valid && in_last && !clr;
  assign len_nxt = len_q + CNT_W'(accept);

  always_ff @(posedge clk) begin
    if (rst || clr || finish) len_q <= '0;
    else                      len_q <= len_nxt;
  end

  for (genvar i = 0; i < VEC_W; i++) begin : g_pos
    bgv_bit_tally #(.CNT_W(CNT_W)) u_tally (
      .clk        (clk),
      .rst        (rst),
      .zero_i     (clr || finish),
      .inc_i      (accept && in_vec[i]),
      .ones_nxt_o (ones_nxt[i*CNT_W +: CNT_W])
    );
  end

  bgv_tie_lfsr #(
    .LFSR_W   (LFSR_W),
    .OUT_W    (VEC_W),
    .TAP_MASK (TAP_MASK),
    .RST_SEED (RST_SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .load_i (seed_load),
    .seed_i (seed_val),
    .step_i (finish),
    .tie_o  (tie_bits)
  );

  bgv_vote_cost #(
    .VEC_W  (VEC_W),
    .CNT_W  (CNT_W),
    .RAW_W  (RAW_W),
    .COST_W (COST_W)
  ) u_vote (
    .ones_i   (ones_nxt),
    .len_i    (len_nxt),
    .tie_i    (tie_bits),
    .bg_o     (bg_d),
    .diff_o   (diff_d),
    .raw_o    (raw_d),
    .cost_o   (cost_d),
    .use_bg_o (use_bg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bg_vec    <= '0;
      diff_cnt  <= '0;
      raw_cost  <= '0;
      bg_cost   <= '0;
      use_bg    <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= finish;
      if (finish) begin
        bg_vec   <= bg_d;
        diff_cnt <= diff_d;
        raw_cost <= raw_d;
        bg_cost  <= cost_d;
        use_bg   <= use_bg_d;
      end
    end
  end
endmodule

// File: rtl/bgv_selector_chk.sv
module bgv_selector_chk #(
  parameter int VEC_W   = 8,
  parameter int MAX_LEN = 1024,
  localparam int RAW_W  = $clog2(VEC_W * MAX_LEN + 1),
  localparam int COST_W = RAW_W + $clog2(RAW_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              in_valid,
  input logic              in_last,
  input logic [VEC_W-1:0]  bg_vec,
  input logic [RAW_W-1:0]  diff_cnt,
  input logic [RAW_W-1:0]  raw_cost,
  input logic [COST_W-1:0] bg_cost,
  input logic              use_bg,
  input logic              res_valid
);
  logic done_in;
  assign done_in = in_valid && in_last && !clr;

  AST_RESULT_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    done_in |=> res_valid); // R7

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done_in |=> !res_valid); // R9

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_in |=> ($stable(bg_vec) && $stable(diff_cnt) && $stable(use_bg))); // R7

  AST_DIFF_HALF: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (2 * int'(diff_cnt) <= int'(raw_cost))); // R4

  AST_RAW_CAP: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(raw_cost) <= VEC_W * MAX_LEN)); // R10

  AST_MODE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (res_valid && use_bg) |-> (COST_W'(raw_cost) > bg_cost)); // R6
endmodule

bind bgv_selector bgv_selector_chk #(.VEC_W(VEC_W), .MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/bgv_selector_tb.sv
module bgv_selector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW     = 4;
  localparam int ML     = 20;
  localparam int LW     = 16;
  localparam logic [LW-1:0] TAPS = 16'hB400;
  localparam int RAW_W  = $clog2(VW * ML + 1);
  localparam int COST_W = RAW_W + $clog2(RAW_W + 1);

  // entry = {last, vector, expected background on last}
  localparam int NTAB = 17;
  localparam logic [8:0] TABLE [NTAB] = '{
    {1'b0, 4'b1110, 4'b0000}, {1'b0, 4'b1001, 4'b0000},
    {1'b0, 4'b1110, 4'b0000}, {1'b0, 4'b1001, 4'b0000},
    {1'b0, 4'b0010, 4'b0000}, {1'b0, 4'b1101, 4'b0000},
    {1'b0, 4'b1001, 4'b0000}, {1'b0, 4'b0000, 4'b0000},
    {1'b0, 4'b0000, 4'b0000}, {1'b1, 4'b1101, 4'b1000},
    {1'b0, 4'b1111, 4'b0000}, {1'b0, 4'b1111, 4'b0000},
    {1'b0, 4'b0001, 4'b0000}, {1'b1, 4'b0011, 4'b0011},
    {1'b1, 4'b0000, 4'b0000},
    {1'b0, 4'b0101, 4'b0000}, {1'b1, 4'b1010, 4'b0111}
  };

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, seed_load = 1'b0;
  logic [LW-1:0] seed_val = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [VW-1:0] in_vec = '0;
  logic [VW-1:0] bg_vec;
  logic [RAW_W-1:0] diff_cnt, raw_cost;
  logic [COST_W-1:0] bg_cost;
  logic use_bg, res_valid;

  int n_chk = 0, n_bad = 0;
  int m_ones [VW];
  int m_len = 0;
  logic [LW-1:0] m_lfsr = 16'h0001;
  logic [VW-1:0] last_bg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bgv_selector #(.VEC_W(VW), .MAX_LEN(ML), .LFSR_W(LW), .TAP_MASK(TAPS),
                 .RST_SEED(16'h0001)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .seed_load(seed_load), .seed_val(seed_val),
    .in_valid(in_valid), .in_vec(in_vec), .in_last(in_last),
    .bg_vec(bg_vec), .diff_cnt(diff_cnt), .raw_cost(raw_cost), .bg_cost(bg_cost),
    .use_bg(use_bg), .res_valid(res_valid));

  function automatic int lg2up(input int x);
    int r = 0;
    while ((1 << r) < x) r++;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < VW; i++) m_ones[i] = 0;
    m_len = 0;
  endtask

  // drives one vector; on last, checks the result one edge later
  task automatic push(input logic [VW-1:0] v, input logic last, input int exp_bg);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_last = last;
    if (m_len < ML) begin
      for (int i = 0; i < VW; i++) m_ones[i] += int'(v[i]);
      m_len++;
    end
    if (last) begin
      int diff, raw, cost;
      logic [VW-1:0] ebg;
      diff = 0;
      for (int i = 0; i < VW; i++) begin
        int z;
        z = m_len - m_ones[i];
        ebg[i] = (m_ones[i] > z) ? 1'b1 : (m_ones[i] < z) ? 1'b0 : m_lfsr[i];
        diff += (m_ones[i] < z) ? m_ones[i] : z;
      end
      raw  = VW * m_len;
      cost = diff * lg2up(raw);
      @(posedge clk); #1;
      check("R7 res_valid", int'(res_valid), 1);
      check("R2/R3 bg_vec", int'(bg_vec), int'(ebg));
      if (exp_bg >= 0) check("R2/R3 bg_vec table", int'(bg_vec), exp_bg);
      check("R4 diff_cnt", int'(diff_cnt), diff);
      check("R5 raw_cost", int'(raw_cost), raw);
      check("R5 bg_cost", int'(bg_cost), cost);
      check("R6 use_bg", int'(use_bg), int'(cost < raw));
      last_bg = ebg;
      m_lfsr = {m_lfsr[LW-2:0], ^(m_lfsr & TAPS)};
      model_clear();
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 bg_vec", int'(bg_vec), 0);
    check("R1 raw_cost", int'(raw_cost), 0);
    check("R1 bg_cost", int'(bg_cost), 0);
    check("R1 use_bg", int'(use_bg), 0);

    // R3 seed load
    @(negedge clk); seed_load = 1'b1; seed_val = 16'hACE0; m_lfsr = 16'hACE0;
    @(negedge clk); seed_load = 1'b0;

    // table walk: R2, R3, R4, R5, R6, R8
    for (int k = 0; k < NTAB; k++)
      push(TABLE[k][7:4], TABLE[k][8], TABLE[k][8] ? int'(TABLE[k][3:0]) : -1);

    // R7 hold after the result pulse
    idle(); idle(); idle();
    #1;
    check("R7 res_valid low", int'(res_valid), 0);
    check("R7 bg_vec held", int'(bg_vec), int'(last_bg));

    // R9 clear mid-sequence, last in clear cycle dropped
    push(4'b0000, 1'b0, -1);
    push(4'b0000, 1'b0, -1);
    push(4'b0000, 1'b0, -1);
    @(negedge clk); in_valid = 1'b1; in_vec = 4'b0000; in_last = 1'b1; clr = 1'b1;
    model_clear();
    @(posedge clk); #1;
    check("R9 no result on clr", int'(res_valid), 0);
    @(negedge clk); clr = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    push(4'b1111, 1'b1, 4'b1111);
    check("R9 raw after clr", int'(raw_cost), 4);

    // R10 length cap
    for (int k = 0; k < 24; k++) push(4'b1111, 1'b0, -1);
    push(4'b0000, 1'b1, 4'b1111);
    check("R10 capped raw", int'(raw_cost), VW * ML);

    // R3 zero seed replaced by 1
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    seed_load = 1'b1; seed_val = '0; m_lfsr = 16'h0001;
    @(negedge clk); seed_load = 1'b0;
    push(4'b0101, 1'b0, -1);
    push(4'b1010, 1'b1, 4'b0001);
    idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule